// File: doc/BRIEF.md
# Condition Evaluation and Bit-Test Flag Unit

This unit takes a 4-bit condition selector and decides whether the condition holds against the processor's condition-code status word. It also gives the value that a set-on-condition instruction stores in its destination. The same unit computes the status-word update for a bit-test operation. For a bit-test it reports the selected bit and whether that bit and every bit below it are clear.

Some arithmetic results reach the unit before their flags are written into the status word. For these, a fast-path input lets the zero and sign conditions be taken straight from the result word.

All results are captured on the clock edge that samples the valid strobe, and they hold until the next strobe. Decode and the arithmetic unit sit outside this block.

Top module: `ccflag_eval`

## Requirements
- R1: While reset is asserted and after it is released, `cond_o`, `scc_o` and `ccs_o` read zero until the first valid strobe.
- R2: The outputs change only on the rising edge where `valid_i` is high. With `valid_i` low, all outputs hold their values.
- R3: Status bits are C = bit 0, V = bit 1, Z = bit 2, N = bit 3. Condition codes 0 to 7 test one flag each, with `fast_i` low: 0 is C clear, 1 is C set, 2 is Z clear, 3 is Z set, 4 is V clear, 5 is V set, 6 is N clear, 7 is N set.
- R4: Code 8 is true when C or Z is set. Code 9 is true when both C and Z are clear.
- R5: Code 10 is true when N equals V, and code 11 when N differs from V. Code 12 is true when Z is clear and N equals V. Code 13 is true when Z is set or N differs from V.
- R6: Code 14 is always true. Code 15 is true when the P flag (status bit 7) is set.
- R7: When `fast_i` is high, codes 2, 3, 6 and 7 ignore the status flags. Code 2 is true for a non-zero `result_i`, code 3 for a zero `result_i`, code 6 when `result_i[31]` is 0, and code 7 when it is 1. The other codes still use the flags.
- R8: `scc_o` is exactly 1 when the condition is true and exactly 0 when it is false.
- R9: For a bit-test (`btst_i` high), the index is `btst_idx_i[4:0]` and the higher index bits are ignored. N becomes the selected bit of `btst_val_i`. Z is set only when the selected bit and all bits below it are zero, and index 31 covers the whole word.
- R10: A bit-test clears X (status bit 4). All other status bits, apart from N and Z, pass through unchanged.
- R11: A strobe with `btst_i` low copies `ccs_i` to `ccs_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Capture strobe |
| btst_i | input | 1 | Selects the bit-test status update |
| cond_i | input | 4 | Condition selector |
| ccs_i | input | 16 | Current status word |
| fast_i | input | 1 | Flags not yet written; use `result_i` for zero/sign conditions |
| result_i | input | 32 | Last arithmetic result |
| btst_val_i | input | 32 | Word being bit-tested |
| btst_idx_i | input | 32 | Bit index operand (low 5 bits used) |
| cond_o | output | 1 | Registered condition result |
| scc_o | output | 32 | Set-on-condition value, 0 or 1 |
| ccs_o | output | 16 | Registered updated status word |

## Verification
On every cycle, the assertions check the following:
- outputs hold while no strobe is present;
- the always condition yields true;
- a bit-test clears X and keeps C and V;
- Z and N are never both set after a bit-test;
- a plain strobe passes the status word through unchanged.

Only the bench scenarios can show the rest. That covers the full truth table of all sixteen codes over every flag combination, and the fast-path decisions from the result word. It also covers the bit-test mask at its edges: index 0, index 31, and index bits above the low five.

// File: rtl/ccflag_eval.sv
module ccflag_eval #(
  parameter int DW    = 32,
  parameter int CCS_W = 16,
  parameter int X_BIT = 4,
  parameter int P_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             btst_i,
  input  logic [3:0]       cond_i,
  input  logic [CCS_W-1:0] ccs_i,
  input  logic             fast_i,
  input  logic [DW-1:0]    result_i,
  input  logic [DW-1:0]    btst_val_i,
  input  logic [DW-1:0]    btst_idx_i,
  output logic             cond_o,
  output logic [DW-1:0]    scc_o,
  output logic [CCS_W-1:0] ccs_o
);
  localparam int IDX_W = $clog2(DW);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(DW - 1);

  logic fc, fv, fz, fn, fp;
  assign fc = ccs_i[0];
  assign fv = ccs_i[1];
  assign fz = ccs_i[2];
  assign fn = ccs_i[3];
  assign fp = ccs_i[P_BIT];

  logic flag_hit, fast_hit, use_fast, cond_next;
  logic res_zero;
  assign res_zero = (result_i == '0);

  always_comb begin
    case (cond_i)
      4'd0:  flag_hit = !fc;
      4'd1:  flag_hit = fc;
      4'd2:  flag_hit = !fz;
      4'd3:  flag_hit = fz;
      4'd4:  flag_hit = !fv;
      4'd5:  flag_hit = fv;
      4'd6:  flag_hit = !fn;
      4'd7:  flag_hit = fn;
      4'd8:  flag_hit = fc | fz;
      4'd9:  flag_hit = !(fc | fz);
      4'd10: flag_hit = !(fn ^ fv);
      4'd11: flag_hit = fn ^ fv;
      4'd12: flag_hit = !fz & !(fn ^ fv);
      4'd13: flag_hit = fz | (fn ^ fv);
      4'd14: flag_hit = 1'b1;
      default: flag_hit = fp;
    endcase
  end

  always_comb begin
    case (cond_i)
      4'd2:    fast_hit = !res_zero;
      4'd3:    fast_hit = res_zero;
      4'd6:    fast_hit = !result_i[DW-1];
      default: fast_hit = result_i[DW-1];
    endcase
  end

  assign use_fast  = fast_i && (cond_i == 4'd2 || cond_i == 4'd3 ||
                                cond_i == 4'd6 || cond_i == 4'd7);
  assign cond_next = use_fast ? fast_hit : flag_hit;

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    low_mask;
  logic             sel_bit, below_zero;
  logic             unused_idx_hi;
  assign idx           = btst_idx_i[IDX_W-1:0];
  assign unused_idx_hi = ^btst_idx_i[DW-1:IDX_W];
  assign sel_bit       = btst_val_i[idx];
  assign low_mask      = {DW{1'b1}} >> (TOP - idx);
  assign below_zero    = ((btst_val_i & low_mask) == '0);

  logic [CCS_W-1:0] ccs_btst;
  always_comb begin
    ccs_btst        = ccs_i;
    ccs_btst[X_BIT] = 1'b0;
    ccs_btst[3]     = sel_bit;
    ccs_btst[2]     = below_zero;
  end

  logic cond_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      ccs_o  <= '0;
    end else if (valid_i) begin
      cond_q <= cond_next;
      ccs_o  <= btst_i ? ccs_btst : ccs_i;
    end
  end

  assign cond_o = cond_q;
  assign scc_o  = {{(DW-1){1'b0}}, cond_q};

  // R2: no strobe, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(ccs_o) && $stable(cond_o));
  // R6: always condition
  a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && cond_i == 4'd14 |=> cond_o);
  // R10: X cleared, C and V kept
  a_r10_xclr: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && btst_i |=> !ccs_o[X_BIT] && ccs_o[1:0] == $past(ccs_i[1:0]));
  // R9: Z set means the selected bit was zero
  a_r9_zn: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && btst_i |=> !(ccs_o[2] && ccs_o[3]));
  // R11: pass-through
  a_r11_pass: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !btst_i |=> ccs_o == $past(ccs_i));
endmodule

// File: tb/ccflag_eval_test.sv
module ccflag_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, btst_i = 1'b0, fast_i = 1'b0;
  logic [3:0]  cond_i = '0;
  logic [15:0] ccs_i = '0;
  logic [31:0] result_i = '0, btst_val_i = '0, btst_idx_i = '0;
  logic        cond_o;
  logic [31:0] scc_o;
  logic [15:0] ccs_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ccflag_eval uut (.clk, .rst_n, .valid_i, .btst_i, .cond_i, .ccs_i, .fast_i,
                   .result_i, .btst_val_i, .btst_idx_i, .cond_o, .scc_o, .ccs_o);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic ref_cond(logic [3:0] c, logic [15:0] s, logic f, logic [31:0] r);
    logic C = s[0], V = s[1], Z = s[2], N = s[3];
    if (f && c == 2) return r != 0;
    if (f && c == 3) return r == 0;
    if (f && c == 6) return r[31] == 0;
    if (f && c == 7) return r[31] == 1;
    case (c)
      0: return C == 0;   1: return C == 1;
      2: return Z == 0;   3: return Z == 1;
      4: return V == 0;   5: return V == 1;
      6: return N == 0;   7: return N == 1;
      8: return C || Z;   9: return !C && !Z;
      10: return N == V;  11: return N != V;
      12: return !Z && N == V;
      13: return Z || N != V;
      14: return 1'b1;
      default: return s[7];
    endcase
  endfunction

  task automatic strobe(logic bt, logic [3:0] c, logic [15:0] s, logic f,
                        logic [31:0] r, logic [31:0] bv, logic [31:0] bi);
    @(negedge clk);
    btst_i = bt; cond_i = c; ccs_i = s; fast_i = f;
    result_i = r; btst_val_i = bv; btst_idx_i = bi; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cond", {31'b0, cond_o}, 0);
    check("R1 scc", scc_o, 0);
    check("R1 ccs", {16'b0, ccs_o}, 0);
  endtask

  task automatic t_flag_conds();
    for (int p = 0; p < 2; p++)
      for (int fl = 0; fl < 16; fl++)
        for (int c = 0; c < 16; c++) begin
          logic [15:0] s = 16'(fl) | (p != 0 ? 16'h0080 : 16'h0);
          logic e = ref_cond(4'(c), s, 1'b0, 32'h0);
          strobe(1'b0, 4'(c), s, 1'b0, 32'h0, 32'h0, 32'h0);
          if (c < 8)       check("R3 cond", {31'b0, cond_o}, {31'b0, e});
          else if (c < 10) check("R4 cond", {31'b0, cond_o}, {31'b0, e});
          else if (c < 14) check("R5 cond", {31'b0, cond_o}, {31'b0, e});
          else             check("R6 cond", {31'b0, cond_o}, {31'b0, e});
          check("R8 scc", scc_o, {31'b0, e});
          check("R11 pass", {16'b0, ccs_o}, {16'b0, s});
        end
  endtask

  task automatic t_fast();
    logic [31:0] rs [4] = '{32'h0, 32'h1, 32'h8000_0000, 32'h7fff_ffff};
    logic [15:0] fl [2] = '{16'h0000, 16'h000f};
    foreach (rs[i]) foreach (fl[j])
      for (int c = 0; c < 16; c++) begin
        logic e = ref_cond(4'(c), fl[j], 1'b1, rs[i]);
        strobe(1'b0, 4'(c), fl[j], 1'b1, rs[i], 32'h0, 32'h0);
        check("R7 fast", {31'b0, cond_o}, {31'b0, e});
        check("R8 scc", scc_o, {31'b0, e});
      end
  endtask

  task automatic t_btst();
    logic [31:0] vals [8] = '{32'h10, 32'h10, 32'h10, 32'h8000_0000, 32'h0, 32'h1, 32'h1, 32'h20};
    logic [31:0] idxs [8] = '{32'd4, 32'd3, 32'd5, 32'd31, 32'd31, 32'h25, 32'd0, 32'hffff_ffe5};
    logic [15:0] bases [2] = '{16'hffff, 16'h0010};
    foreach (vals[i]) foreach (bases[k]) begin
      int ix = int'(idxs[i][4:0]);
      logic n = vals[i][ix];
      logic z = 1'b1;
      logic [15:0] e = bases[k];
      for (int b = 0; b <= ix; b++) if (vals[i][b]) z = 1'b0;
      e[4] = 1'b0; e[3] = n; e[2] = z;
      strobe(1'b1, 4'd14, bases[k], 1'b0, 32'h0, vals[i], idxs[i]);
      check("R9 N", {31'b0, ccs_o[3]}, {31'b0, n});
      check("R9 Z", {31'b0, ccs_o[2]}, {31'b0, z});
      check("R10 ccs", {16'b0, ccs_o}, {16'b0, e});
    end
  endtask

  task automatic t_hold();
    strobe(1'b0, 4'd3, 16'h0004, 1'b0, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    cond_i = 4'd2; ccs_i = 16'h1234; btst_i = 1'b1; btst_val_i = 32'hffff_ffff;
    @(negedge clk); @(negedge clk);
    check("R2 cond", {31'b0, cond_o}, 1);
    check("R2 ccs", {16'b0, ccs_o}, 32'h0004);
    strobe(1'b0, 4'd0, 16'ha5c3, 1'b0, 32'h0, 32'h0, 32'h0);
    check("R11 pass", {16'b0, ccs_o}, 32'ha5c3);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flag_conds();
    t_fast();
    t_btst();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule